// File: doc/BRIEF.md
# Single-Check-Symbol Erasure Codec over GF(2^16)

This block protects a word of eight 16-bit data symbols with one 16-bit check symbol. The check symbol is computed in the Galois field GF(2^16) built from the primitive polynomial x^16 + x^12 + x^3 + x + 1. A codeword is valid when, read as a polynomial in the root element 60000 (0xEA60), it evaluates to zero. The same single check symbol serves two purposes. It detects any single corrupted symbol. It also rebuilds one symbol whose position is already known, which is called an erasure.

A caller hands over one request at a time on a valid/ready channel. Each request carries the nine symbols, an operation code and an optional erasure position. The operations are:

- Encode: compute a fresh check symbol.
- Check: report the syndrome without changing anything.
- Repair: report the syndrome and, when an erasure is named, XOR the recovered error value into that symbol.

Finding out which symbol is bad belongs to the caller. The result comes back on a second valid/ready channel, together with three flags: error seen, correction applied, and erasure requested but nothing wrong.

Codeword positions are numbered as follows. Position 0 is the check symbol. Position k+1 is data lane k, which occupies bits [16k+15:16k] of the data bus. The value of a codeword is the sum over i of symbol_i · 60000^i.

Top module: `rsec_erasure_codec`

## Requirements
- R1: Encode (op code 0) returns the data unchanged and a check symbol equal to the sum over data lanes k of lane_k · 60000^(k+1) in GF(2^16) with polynomial 0x1100B. With only lane 0 equal to 1 and the others 0, the check symbol is 0xEA60.
- R2: Check (op code 1, and the unused code 3 behaves the same) returns all nine symbols unchanged. It reports the syndrome S = sum of symbol_i · 60000^i, and sets the error flag exactly when S is nonzero.
- R3: Corrupting any single position 0..8 of a valid codeword by any nonzero value always sets the error flag.
- R4: Repair (op code 2) with the erasure enable set, a position j in 0..8 and a nonzero syndrome returns the codeword with symbol j restored to its value before corruption. It sets the correction and error flags and reports the original syndrome.
- R5: Repair with the erasure enable set and a zero syndrome returns the symbols unchanged. It sets the flag for an erasure with nothing wrong, and clears the correction and error flags.
- R6: Repair with the erasure enable clear, or with a position above 8, changes no symbol and leaves the correction flag clear. The error flag still follows the syndrome.
- R7: Only one request is in flight at a time. While a response waits for rsp_ready, req_ready stays low, and the response fields hold their values.
- R8: In a cycle where the pending response is taken, req_ready is high, so a waiting request is accepted at that same edge.
- R9: After reset, rsp_valid is low and req_ready is high.
- R10: Encode responses carry a zero syndrome and all three flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_op | input | 2 | 0 encode, 1 check, 2 repair, 3 check |
| req_data | input | 128 | Eight data lanes, lane k in bits [16k+15:16k] |
| req_check | input | 16 | Stored check symbol (ignored by encode) |
| req_erase | input | 1 | Erasure position is given |
| req_pos | input | 4 | Erasure position, 0 = check symbol, k+1 = data lane k |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed at this edge when valid |
| rsp_data | output | 128 | Returned data lanes |
| rsp_check | output | 16 | Returned or computed check symbol |
| rsp_syndrome | output | 16 | Syndrome of the received word (zero for encode) |
| rsp_err | output | 1 | Syndrome nonzero |
| rsp_fixed | output | 1 | Erasure correction applied |
| rsp_clean | output | 1 | Erasure requested but syndrome zero |

## Verification
Two events can share one clock edge: the caller taking a held response, and the next request being accepted. The bench provokes this by parking a second request on the request channel while the first response is back-pressured. It checks that req_ready stays low while the response waits. It then checks that req_ready rises in the very cycle rsp_ready is raised. Finally it confirms that the second request's result is correct, so the overlap has not damaged it. Corruption and repair are driven at every one of the nine positions, with random data and random error values. The expected syndromes and restored words are computed from the field definition in the bench.

// File: rtl/rsec_pkg.sv
package rsec_pkg;
    localparam int SYM_W      = 16;
    localparam int DATA_LANES = 8;
    localparam int LANES      = DATA_LANES + 1;
    localparam int POS_W      = $clog2(LANES);
    localparam logic [SYM_W-1:0] POLY_LOW = 16'h100B;
    localparam logic [SYM_W-1:0] ROOT     = 16'hEA60;

    typedef logic [SYM_W-1:0] sym_t;
    typedef sym_t [LANES-1:0] word_t;

    typedef enum logic [1:0] {
        OP_ENCODE = 2'd0,
        OP_CHECK  = 2'd1,
        OP_REPAIR = 2'd2,
        OP_SPARE  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SYND,
        ST_SCALE,
        ST_DONE
    } state_e;

    typedef struct packed {
        logic err;
        logic fixed;
        logic clean;
    } flags_t;

    function automatic sym_t gf_mul(input sym_t a, input sym_t b);
        sym_t p;
        sym_t x;
        p = '0;
        x = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) p = p ^ x;
            x = x[SYM_W-1] ? ((x << 1) ^ POLY_LOW) : (x << 1);
        end
        return p;
    endfunction

    function automatic sym_t gf_inv(input sym_t a);
        sym_t r;
        sym_t base;
        logic [SYM_W-1:0] ex;
        r    = 16'h0001;
        base = a;
        ex   = 16'hFFFE;
        for (int i = 0; i < SYM_W; i++) begin
            if (ex[i]) r = gf_mul(r, base);
            base = gf_mul(base, base);
        end
        return r;
    endfunction

    localparam sym_t ROOT_INV = gf_inv(ROOT);
endpackage

// File: rtl/rsec_gf_scale.sv
module rsec_gf_scale
    import rsec_pkg::*;
#(
    parameter sym_t K = 16'h0001
) (
    input  sym_t x,
    output sym_t y
);
    assign y = gf_mul(x, K);
endmodule

// File: rtl/rsec_lane_fix.sv
module rsec_lane_fix
    import rsec_pkg::*;
(
    input  word_t            in_word,
    input  logic             apply,
    input  logic [POS_W-1:0] pos,
    input  sym_t             value,
    output word_t            out_word
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign out_word[i] = (apply && (pos == POS_W'(i))) ? (in_word[i] ^ value) : in_word[i];
    end
endmodule

// File: rtl/rsec_erasure_codec.sv
module rsec_erasure_codec
    import rsec_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [1:0]                  req_op,
    input  logic [DATA_LANES*SYM_W-1:0] req_data,
    input  logic [SYM_W-1:0]            req_check,
    input  logic                        req_erase,
    input  logic [POS_W-1:0]            req_pos,
    output logic                        rsp_valid,
    input  logic                        rsp_ready,
    output logic [DATA_LANES*SYM_W-1:0] rsp_data,
    output logic [SYM_W-1:0]            rsp_check,
    output logic [SYM_W-1:0]            rsp_syndrome,
    output logic                        rsp_err,
    output logic                        rsp_fixed,
    output logic                        rsp_clean
);
    state_e           state_q;
    op_e              op_q;
    word_t            syms_q;
    word_t            syms_in;
    word_t            syms_fixed;
    logic             erase_q;
    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] idx_q;
    logic [POS_W-1:0] cnt_q;
    sym_t             acc_q;
    sym_t             acc_scaled;
    sym_t             acc_next;
    sym_t             lane_in;
    sym_t             ev_q;
    sym_t             ev_scaled;
    sym_t             syn_q;
    flags_t           flags_q;
    logic             accept;
    logic             fix_now;

    assign req_ready = (state_q == ST_IDLE) || ((state_q == ST_DONE) && rsp_ready);
    assign accept    = req_valid && req_ready;
    assign fix_now   = (state_q == ST_SCALE) && (cnt_q == '0);

    always_comb begin
        syms_in[0] = req_check;
        for (int i = 1; i < LANES; i++) begin
            syms_in[i] = req_data[(i-1)*SYM_W +: SYM_W];
        end
        for (int i = 1; i < LANES; i++) begin
            rsp_data[(i-1)*SYM_W +: SYM_W] = syms_q[i];
        end
    end

    always_comb begin
        lane_in = syms_q[idx_q];
        if ((idx_q == '0) && (op_q == OP_ENCODE)) lane_in = '0;
    end

    rsec_gf_scale #(.K(ROOT)) u_root_step (
        .x (acc_q),
        .y (acc_scaled)
    );

    rsec_gf_scale #(.K(ROOT_INV)) u_inv_step (
        .x (ev_q),
        .y (ev_scaled)
    );

    assign acc_next = acc_scaled ^ lane_in;

    rsec_lane_fix u_fix (
        .in_word  (syms_q),
        .apply    (fix_now),
        .pos      (pos_q),
        .value    (ev_q),
        .out_word (syms_fixed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= OP_CHECK;
            syms_q  <= '0;
            erase_q <= 1'b0;
            pos_q   <= '0;
            idx_q   <= '0;
            cnt_q   <= '0;
            acc_q   <= '0;
            ev_q    <= '0;
            syn_q   <= '0;
            flags_q <= '0;
        end else begin
            case (state_q)
                ST_SYND: begin
                    acc_q <= acc_next;
                    if (idx_q == '0) begin
                        if (op_q == OP_ENCODE) begin
                            syms_q[0] <= acc_next;
                            state_q   <= ST_DONE;
                        end else begin
                            syn_q       <= acc_next;
                            flags_q.err <= (acc_next != '0);
                            if ((op_q == OP_REPAIR) && erase_q) begin
                                if (acc_next != '0) begin
                                    ev_q    <= acc_next;
                                    cnt_q   <= pos_q;
                                    state_q <= ST_SCALE;
                                end else begin
                                    flags_q.clean <= 1'b1;
                                    state_q       <= ST_DONE;
                                end
                            end else begin
                                state_q <= ST_DONE;
                            end
                        end
                    end else begin
                        idx_q <= idx_q - 1'b1;
                    end
                end
                ST_SCALE: begin
                    if (fix_now) begin
                        syms_q        <= syms_fixed;
                        flags_q.fixed <= 1'b1;
                        state_q       <= ST_DONE;
                    end else begin
                        ev_q  <= ev_scaled;
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_DONE: begin
                    if (rsp_ready) state_q <= ST_IDLE;
                end
                default: ;
            endcase
            if (accept) begin
                state_q <= ST_SYND;
                op_q    <= op_e'(req_op);
                syms_q  <= syms_in;
                erase_q <= req_erase && (req_pos < POS_W'(LANES));
                pos_q   <= req_pos;
                idx_q   <= POS_W'(LANES - 1);
                acc_q   <= '0;
                syn_q   <= '0;
                flags_q <= '0;
            end
        end
    end

    assign rsp_valid    = (state_q == ST_DONE);
    assign rsp_check    = syms_q[0];
    assign rsp_syndrome = syn_q;
    assign rsp_err      = flags_q.err;
    assign rsp_fixed    = flags_q.fixed;
    assign rsp_clean    = flags_q.clean;
endmodule

// File: rtl/rsec_codec_chk.sv
module rsec_codec_chk
    import rsec_pkg::*;
(
    input logic                        clk,
    input logic                        rst,
    input logic                        req_ready,
    input logic                        rsp_valid,
    input logic                        rsp_ready,
    input logic [DATA_LANES*SYM_W-1:0] rsp_data,
    input logic [SYM_W-1:0]            rsp_check,
    input logic [SYM_W-1:0]            rsp_syndrome,
    input logic                        rsp_err,
    input logic                        rsp_fixed,
    input logic                        rsp_clean
);
    AST_RSP_STABLE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_check) && $stable(rsp_syndrome)); // R7
    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |-> !req_ready); // R7
    AST_TAKE_FREES: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_ready |-> req_ready); // R8
    AST_FIX_NEEDS_ERR: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_fixed |-> rsp_err && !rsp_clean); // R4
    AST_CLEAN_ZERO: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_clean |-> (rsp_syndrome == '0) && !rsp_err && !rsp_fixed); // R5
    AST_ERR_MATCHES_SYN: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_err == (rsp_syndrome != '0))); // R2
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rsp_valid && req_ready); // R9
endmodule

bind rsec_erasure_codec rsec_codec_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_data     (rsp_data),
    .rsp_check    (rsp_check),
    .rsp_syndrome (rsp_syndrome),
    .rsp_err      (rsp_err),
    .rsp_fixed    (rsp_fixed),
    .rsp_clean    (rsp_clean)
);

// File: tb/tb_rsec_erasure_codec.sv
module tb_rsec_erasure_codec;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [1:0]   req_op = 2'd0;
    logic [127:0] req_data = '0;
    logic [15:0]  req_check = '0;
    logic         req_erase = 1'b0;
    logic [3:0]   req_pos = '0;
    logic         rsp_valid;
    logic         rsp_ready = 1'b0;
    logic [127:0] rsp_data;
    logic [15:0]  rsp_check;
    logic [15:0]  rsp_syndrome;
    logic         rsp_err;
    logic         rsp_fixed;
    logic         rsp_clean;

    int vectors = 0;
    int misses  = 0;

    logic [127:0] g_data;
    logic [15:0]  g_check, g_syn;
    logic         g_err, g_fix, g_clean;

    always #10 clk = ~clk;

    rsec_erasure_codec dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_data(req_data), .req_check(req_check),
        .req_erase(req_erase), .req_pos(req_pos), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_check(rsp_check),
        .rsp_syndrome(rsp_syndrome), .rsp_err(rsp_err), .rsp_fixed(rsp_fixed),
        .rsp_clean(rsp_clean)
    );

    function automatic logic [15:0] fmul(input logic [15:0] a, input logic [15:0] b);
        logic [31:0] prod = '0;
        for (int i = 0; i < 16; i++) if (b[i]) prod = prod ^ (32'(a) << i);
        for (int i = 31; i >= 16; i--) if (prod[i]) prod = prod ^ (32'h1100B << (i - 16));
        return prod[15:0];
    endfunction

    function automatic logic [15:0] root_pow(input int n);
        logic [15:0] r = 16'h0001;
        for (int i = 0; i < n; i++) r = fmul(r, 16'd60000);
        return r;
    endfunction

    function automatic logic [15:0] ref_syn(input logic [127:0] d, input logic [15:0] c);
        logic [15:0] s = c;
        for (int k = 0; k < 8; k++) s = s ^ fmul(d[16*k +: 16], root_pow(k + 1));
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input logic [143:0] act, input logic [143:0] exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] op, input logic [127:0] d, input logic [15:0] c,
                        input logic en, input logic [3:0] pos);
        @(negedge clk);
        req_op = op; req_data = d; req_check = c; req_erase = en; req_pos = pos;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic recv();
        int hold;
        rsp_ready = 1'b0;
        while (!rsp_valid) @(negedge clk);
        g_data = rsp_data; g_check = rsp_check; g_syn = rsp_syndrome;
        g_err = rsp_err; g_fix = rsp_fixed; g_clean = rsp_clean;
        hold = $urandom_range(0, 2);
        for (int h = 0; h < hold; h++) @(negedge clk);
        rsp_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    task automatic run(input logic [1:0] op, input logic [127:0] d, input logic [15:0] c,
                       input logic en, input logic [3:0] pos);
        send(op, d, c, en, pos);
        recv();
    endtask

    task automatic corrupt(input logic [127:0] d, input logic [15:0] c, input int j,
                           input logic [15:0] e, output logic [127:0] od, output logic [15:0] oc);
        od = d; oc = c;
        if (j == 0) oc = c ^ e;
        else od[16*(j-1) +: 16] = d[16*(j-1) +: 16] ^ e;
    endtask

    task automatic round(input logic [127:0] d, input int j, input logic [15:0] e, input bit bad_pos);
        logic [15:0]  c, bc, s;
        logic [127:0] bd;
        c = ref_syn(d, 16'h0);
        run(2'd0, d, 16'hDEAD, 1'b0, 4'd0);
        check(g_check == c && g_data == d, "R1 encode", {g_data, g_check}, {d, c});
        check(g_syn == 16'h0 && !g_err && !g_fix && !g_clean, "R10 encode flags",
              {g_syn, g_err, g_fix, g_clean}, 144'h0);
        corrupt(d, c, j, e, bd, bc);
        s = ref_syn(bd, bc);
        run(2'd1, bd, bc, 1'b1, 4'(j));
        check(g_err && g_syn == s && g_data == bd && g_check == bc && !g_fix, "R2 R3 check",
              {g_data, g_check, g_syn, g_err}, {bd, bc, s, 1'b1});
        run(2'd2, bd, bc, 1'b1, 4'(j));
        check(g_data == d && g_check == c && g_fix && g_err && g_syn == s, "R4 repair",
              {g_data, g_check, g_syn, g_fix}, {d, c, s, 1'b1});
        run(2'd2, d, c, 1'b1, 4'(j));
        check(g_clean && !g_fix && !g_err && g_data == d && g_check == c, "R5 clean erase",
              {g_data, g_check, g_clean, g_fix}, {d, c, 1'b1, 1'b0});
        if (bad_pos) begin
            run(2'd2, bd, bc, 1'b1, 4'($urandom_range(9, 15)));
            check(!g_fix && g_err && g_data == bd && g_check == bc, "R6 position above 8",
                  {g_data, g_check, g_fix}, {bd, bc, 1'b0});
            run(2'd2, bd, bc, 1'b0, 4'(j));
            check(!g_fix && g_err && g_data == bd && g_check == bc, "R6 erase disabled",
                  {g_data, g_check, g_fix}, {bd, bc, 1'b0});
        end
    endtask

    function automatic logic [127:0] rand_data();
        logic [127:0] d;
        for (int k = 0; k < 4; k++) d[32*k +: 32] = $urandom();
        return d;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        misses++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        logic [127:0] d;
        logic [15:0]  c2;
        void'($urandom(32'h5EC0DE));
        repeat (4) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!rsp_valid && req_ready, "R9 reset state", {rsp_valid, req_ready}, {1'b0, 1'b1});

        run(2'd0, 128'h0, 16'h1234, 1'b0, 4'd0);
        check(g_check == 16'h0, "R1 zero data", g_check, 16'h0);
        run(2'd0, 128'h1, 16'h0, 1'b0, 4'd0);
        check(g_check == 16'hEA60, "R1 unit lane 0", g_check, 16'hEA60);
        run(2'd3, 128'h1, 16'hEA60, 1'b0, 4'd0);
        check(!g_err && g_syn == 16'h0, "R2 code 3 clean", {g_err, g_syn}, 17'h0);

        for (int j = 0; j < 9; j++) round(rand_data(), j, 16'hFFFF, 1'b0);
        for (int j = 0; j < 9; j++) round(128'h0, j, 16'h0001, 1'b0);
        for (int n = 0; n < 40; n++) begin
            logic [15:0] e;
            e = 16'($urandom_range(1, 65535));
            round(rand_data(), $urandom_range(0, 8), e, (n % 4) == 0);
        end

        d = rand_data();
        c2 = ref_syn(d, 16'h0);
        send(2'd0, d, 16'h0, 1'b0, 4'd0);
        @(negedge clk);
        req_op = 2'd1; req_data = d; req_check = c2; req_erase = 1'b0; req_valid = 1'b1;
        while (!rsp_valid) @(negedge clk);
        check(!req_ready, "R7 busy while held", req_ready, 1'b0);
        g_check = rsp_check;
        @(negedge clk);
        @(negedge clk);
        check(rsp_valid && rsp_check == g_check && !req_ready, "R7 held response",
              {rsp_valid, rsp_check, req_ready}, {1'b1, c2, 1'b0});
        rsp_ready = 1'b1;
        #1;
        check(req_ready, "R8 ready in take cycle", req_ready, 1'b1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        rsp_ready = 1'b0;
        recv();
        check(!g_err && g_syn == 16'h0 && g_data == d && g_check == c2, "R8 overlapped request",
              {g_data, g_check, g_err}, {d, c2, 1'b0});

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule